// File: doc/BRIEF.md
# Clock output enable controller

This block is the digital control core of a multi-output clock buffer. It watches an asynchronous power-good input (low means power down), a PLL lock flag and one active-low enable pin per differential output pair. From these and a handful of configuration bits supplied by a register file, it decides cycle by cycle whether each differential pair runs or is parked at a programmed static level. It also decides whether the single-ended reference output is high impedance, stopped or running.

On the first rising edge of power-good after reset, the block captures two board straps: a bus address select and a tri-level spread select. It holds both until the next reset. All asynchronous control inputs pass through two-flop synchronisers. A one-cycle stability filter follows, so a pulse that lasts only one sample never reaches an output. The run and stop results are modelled as registered enable and state signals; no real clock muxing takes place.

Top module: `clkout_ctl`

## Requirements
- R1: Straps are captured only on the first filtered rising edge of power-good after reset. Later power-good cycles leave `bus_addr` and `ss_sel` unchanged, and `straps_valid` goes to 1 when the capture happens.
- R2: `bus_addr` is 7'b1101000 when the captured address strap is 0 and 7'b1101010 when it is 1. Reset value is 7'b1101000.
- R3: The spread strap `ss_strap_in` is encoded as 2'b00 = low, 2'b01 = mid and 2'b1x = high. It is decoded into `ss_sel` as 2'b00 = spread off, 2'b01 = -0.25 %, and 2'b10 = -0.5 %. The code 2'b11 never appears.
- R4: While filtered power-good is low, every bit of `dif_run` is 0, whatever the enable pins or bits are.
- R5: A stopped pair drives `dif_lvl_t` = `reg_stop_lvl[1]` and `dif_lvl_c` = `reg_stop_lvl[0]`. A running pair drives 0 on both.
- R6: With power-good high and lock high, `dif_run[i]` is 1 exactly when `reg_oe_bits[i]` is 1 and `oe_n_in[i]` is 0.
- R7: While filtered lock is low, every bit of `dif_run` is 0.
- R8: Until the first capture, `ref_state` is 2'b00 (high impedance). The other encodings are 2'b01 = stopped and 2'b10 = running.
- R9: After the first capture, with power-good low, `ref_state` is running if `reg_ref_pd_run` is 1 and stopped otherwise.
- R10: With power-good high, `ref_state` is running if `reg_ref_en` is 1 and stopped otherwise.
- R11: A change on a synchronised control input that lasts a single clock sample has no effect on any output.
- R12: Asserting `rst_n` low returns the block to its never-powered state: `straps_valid` = 0, `ref_state` = high impedance, `dif_run` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_in | input | 1 | Power-good / power-down, asynchronous, high = powered |
| pll_lock_in | input | 1 | PLL lock flag, asynchronous |
| oe_n_in | input | NUM_OUT | Active-low per-pair enable pins, asynchronous |
| adr_strap_in | input | 1 | Address select strap |
| ss_strap_in | input | 2 | Tri-level spread strap as two comparator outputs |
| reg_oe_bits | input | NUM_OUT | Per-pair enable bits from the register file |
| reg_stop_lvl | input | 2 | Stopped level: [1] true leg, [0] complement leg |
| reg_ref_en | input | 1 | Reference enable while powered |
| reg_ref_pd_run | input | 1 | Keep the reference running in power down |
| bus_addr | output | 7 | Captured 7-bit bus address |
| ss_sel | output | 2 | Decoded spread setting |
| straps_valid | output | 1 | Straps have been captured |
| dif_run | output | NUM_OUT | Per-pair run control |
| dif_lvl_t | output | NUM_OUT | Per-pair true-leg static level |
| dif_lvl_c | output | NUM_OUT | Per-pair complement-leg static level |
| ref_state | output | 2 | Reference output state |

## Verification
The hardest case to reach is a second power-good rising edge that meets strap pins which have changed since the first edge. The stimulus holds power-good low through reset so the never-powered reference state is visible. It then raises power-good once to capture the straps, moves the strap pins, and runs a full power-down and power-up cycle before reading the outputs again. A single-sample glitch on an enable pin is produced by driving the pin for one clock period between falling edges. The run decision is swept over every pairing of the six pins and six register bits.

// File: rtl/clkout_ctl.sv
module clkout_ctl #(
  parameter int NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrgd_in,
  input  logic               pll_lock_in,
  input  logic [NUM_OUT-1:0] oe_n_in,
  input  logic               adr_strap_in,
  input  logic [1:0]         ss_strap_in,
  input  logic [NUM_OUT-1:0] reg_oe_bits,
  input  logic [1:0]         reg_stop_lvl,
  input  logic               reg_ref_en,
  input  logic               reg_ref_pd_run,
  output logic [6:0]         bus_addr,
  output logic [1:0]         ss_sel,
  output logic               straps_valid,
  output logic [NUM_OUT-1:0] dif_run,
  output logic [NUM_OUT-1:0] dif_lvl_t,
  output logic [NUM_OUT-1:0] dif_lvl_c,
  output logic [1:0]         ref_state
);

  localparam int SW = NUM_OUT + 2;
  localparam logic [SW-1:0] SYNC_RST = {2'b00, {NUM_OUT{1'b1}}};
  localparam logic [1:0] REF_HIZ = 2'b00;
  localparam logic [1:0] REF_STOP = 2'b01;
  localparam logic [1:0] REF_RUN = 2'b10;

  logic [SW-1:0] raw, s1, s2, prev, filt;
  logic pg_f, lock_f, pg_d, adr_q;
  logic [NUM_OUT-1:0] oe_n_f, run_nxt;

  assign raw = {pwrgd_in, pll_lock_in, oe_n_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= SYNC_RST;
      s2   <= SYNC_RST;
      prev <= SYNC_RST;
      filt <= SYNC_RST;
    end else begin
      s1   <= raw;
      s2   <= s1;
      prev <= s2;
      filt <= (s2 & ~(s2 ^ prev)) | (filt & (s2 ^ prev));
    end
  end

  assign pg_f   = filt[SW-1];
  assign lock_f = filt[SW-2];
  assign oe_n_f = filt[NUM_OUT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d         <= 1'b0;
      straps_valid <= 1'b0;
      adr_q        <= 1'b0;
      ss_sel       <= 2'b00;
    end else begin
      pg_d <= pg_f;
      if (pg_f && !pg_d && !straps_valid) begin
        straps_valid <= 1'b1;
        adr_q        <= adr_strap_in;
        ss_sel       <= ss_strap_in[1] ? 2'b10 : {1'b0, ss_strap_in[0]};
      end
    end
  end

  assign bus_addr = {5'b11010, adr_q, 1'b0};

  assign run_nxt = {NUM_OUT{pg_f & lock_f}} & reg_oe_bits & ~oe_n_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dif_run   <= '0;
      dif_lvl_t <= '0;
      dif_lvl_c <= '0;
      ref_state <= REF_HIZ;
    end else begin
      dif_run   <= run_nxt;
      dif_lvl_t <= ~run_nxt & {NUM_OUT{reg_stop_lvl[1]}};
      dif_lvl_c <= ~run_nxt & {NUM_OUT{reg_stop_lvl[0]}};
      if (!straps_valid && !(pg_f && !pg_d))
        ref_state <= REF_HIZ;
      else if (pg_f)
        ref_state <= reg_ref_en ? REF_RUN : REF_STOP;
      else
        ref_state <= reg_ref_pd_run ? REF_RUN : REF_STOP;
    end
  end

endmodule

module clkout_ctl_chk #(
  parameter int NUM_OUT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pg_f,
  input logic               lock_f,
  input logic [NUM_OUT-1:0] reg_oe_bits,
  input logic [1:0]         reg_stop_lvl,
  input logic               reg_ref_en,
  input logic [6:0]         bus_addr,
  input logic [1:0]         ss_sel,
  input logic               straps_valid,
  input logic [NUM_OUT-1:0] dif_run,
  input logic [NUM_OUT-1:0] dif_lvl_t,
  input logic [NUM_OUT-1:0] dif_lvl_c,
  input logic [1:0]         ref_state
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  assert_straps_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && straps_valid && $past(straps_valid)) |-> ($stable(bus_addr) && $stable(ss_sel)));

  assert_spread_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_sel != 2'b11);

  assert_stopped_in_pd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dif_run != '0) |-> $past(pg_f));

  assert_stop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (((dif_lvl_t & ~dif_run) == ({NUM_OUT{$past(reg_stop_lvl[1])}} & ~dif_run)) &&
              ((dif_lvl_c & ~dif_run) == ({NUM_OUT{$past(reg_stop_lvl[0])}} & ~dif_run)) &&
              ((dif_lvl_t | dif_lvl_c) & dif_run) == '0));

  assert_bit_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((dif_run & ~$past(reg_oe_bits)) == '0));

  assert_lock_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dif_run != '0) |-> $past(lock_f));

  assert_hiz_before_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |-> (ref_state == 2'b00));

  assert_ref_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && straps_valid && $past(straps_valid) && $past(pg_f)) |->
      (ref_state == ($past(reg_ref_en) ? 2'b10 : 2'b01)));

endmodule

bind clkout_ctl clkout_ctl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_f(pg_f), .lock_f(lock_f),
  .reg_oe_bits(reg_oe_bits), .reg_stop_lvl(reg_stop_lvl), .reg_ref_en(reg_ref_en),
  .bus_addr(bus_addr), .ss_sel(ss_sel), .straps_valid(straps_valid),
  .dif_run(dif_run), .dif_lvl_t(dif_lvl_t), .dif_lvl_c(dif_lvl_c), .ref_state(ref_state)
);

// File: tb/clkout_ctl_bench.sv
module clkout_ctl_bench;
  localparam int N = 6;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrgd_in = 1'b0, pll_lock_in = 1'b0;
  logic [N-1:0] oe_n_in = '0, reg_oe_bits = '1;
  logic adr_strap_in = 1'b0;
  logic [1:0] ss_strap_in = 2'b00, reg_stop_lvl = 2'b00;
  logic reg_ref_en = 1'b1, reg_ref_pd_run = 1'b0;
  logic [6:0] bus_addr;
  logic [1:0] ss_sel, ref_state;
  logic straps_valid;
  logic [N-1:0] dif_run, dif_lvl_t, dif_lvl_c;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_ctl #(.NUM_OUT(N)) u_clkout_ctl (
    .clk(clk), .rst_n(rst_n), .pwrgd_in(pwrgd_in), .pll_lock_in(pll_lock_in),
    .oe_n_in(oe_n_in), .adr_strap_in(adr_strap_in), .ss_strap_in(ss_strap_in),
    .reg_oe_bits(reg_oe_bits), .reg_stop_lvl(reg_stop_lvl), .reg_ref_en(reg_ref_en),
    .reg_ref_pd_run(reg_ref_pd_run), .bus_addr(bus_addr), .ss_sel(ss_sel),
    .straps_valid(straps_valid), .dif_run(dif_run), .dif_lvl_t(dif_lvl_t),
    .dif_lvl_c(dif_lvl_c), .ref_state(ref_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (7) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pg);
    @(negedge clk);
    rst_n = 1'b0;
    pwrgd_in = pg;
    #1;
    chk("R12 straps_valid in reset", straps_valid, 0);
    chk("R12 ref hiz in reset", ref_state, 2'b00);
    chk("R12 dif_run in reset", dif_run, 0);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    adr_strap_in = 1'b1;
    ss_strap_in = 2'b01;
    do_reset(1'b0);
    chk("R8 ref hiz before first power-good", ref_state, 2'b00);
    chk("R12 straps not latched", straps_valid, 0);
    chk("R2 reset address", bus_addr, 7'b1101000);
    chk("R4 stopped while unpowered", dif_run, 0);

    pwrgd_in = 1'b1;
    settle();
    chk("R1 straps latched", straps_valid, 1);
    chk("R2 address strap 1", bus_addr, 7'b1101010);
    chk("R3 mid spread", ss_sel, 2'b01);
    chk("R10 ref running when enabled", ref_state, 2'b10);
    chk("R7 no run before lock", dif_run, 0);

    pll_lock_in = 1'b1;
    for (int p = 0; p < 64; p++) begin
      for (int b = 0; b < 64; b++) begin
        oe_n_in = p[N-1:0];
        reg_oe_bits = b[N-1:0];
        settle();
        chk("R6 run decision", dif_run, ~p[N-1:0] & b[N-1:0]);
      end
    end

    oe_n_in = '0;
    reg_oe_bits = 6'b101010;
    for (int l = 0; l < 4; l++) begin
      reg_stop_lvl = l[1:0];
      settle();
      chk("R5 true level", dif_lvl_t, 6'b010101 & {N{l[1]}});
      chk("R5 comp level", dif_lvl_c, 6'b010101 & {N{l[0]}});
    end
    reg_stop_lvl = 2'b00;
    reg_oe_bits = '1;

    pll_lock_in = 1'b0;
    settle();
    chk("R7 lock loss stops pairs", dif_run, 0);
    pll_lock_in = 1'b1;
    settle();
    chk("R6 all running", dif_run, 6'h3f);

    @(negedge clk) oe_n_in[0] = 1'b1;
    @(negedge clk) oe_n_in[0] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R11 glitch ignored", dif_run, 6'h3f);
    end

    adr_strap_in = 1'b0;
    ss_strap_in = 2'b11;
    pwrgd_in = 1'b0;
    reg_ref_pd_run = 1'b0;
    settle();
    chk("R4 power down stops all", dif_run, 0);
    chk("R9 ref stopped in power down", ref_state, 2'b01);
    reg_ref_pd_run = 1'b1;
    settle();
    chk("R9 ref kept running in power down", ref_state, 2'b10);
    pwrgd_in = 1'b1;
    settle();
    chk("R1 address not resampled", bus_addr, 7'b1101010);
    chk("R1 spread not resampled", ss_sel, 2'b01);
    chk("R6 running again", dif_run, 6'h3f);
    reg_ref_en = 1'b0;
    settle();
    chk("R10 ref stopped by bit", ref_state, 2'b01);
    reg_ref_en = 1'b1;

    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 4; s++) begin
        adr_strap_in = a[0];
        ss_strap_in = s[1:0];
        do_reset(1'b1);
        chk("R2 address strap sweep", bus_addr, a[0] ? 7'b1101010 : 7'b1101000);
        chk("R3 spread sweep", ss_sel, s[1] ? 2'b10 : {1'b0, s[0]});
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule